// File: doc/BRIEF.md
# Cache Line Metadata State Register

This block holds the bookkeeping state of one cache entry. It keeps a six-bit status vector, the address tag, a saturating use counter, the owner and task identifiers of the requester that filled the line, and the time at which the fill happened. Four commands change that state: invalidate, fill (insert), demand touch and a masked status update. An outer cache controller issues one or more of them in a cycle. The stored state is visible on the ports at all times, and the block derives from it the readable, writable, dirty, prefetched and secure queries and a coherence class code.

Readable and valid are kept apart on purpose, so a line that is present can still block reads while a write is outstanding. A fill loads the identity fields but leaves the presence and permission bits untouched. The controller sets those bits with the masked update, which lets it sequence a fill in two steps. The block does not compare tags, choose a victim, store data or decide coherence transitions. It only keeps the state of one line and reports it.

Top module: `line_meta_reg`

## Requirements
- R1: A synchronous active-high reset puts the line into the invalidated state. Status is 0, the use count is 0, owner and task are all ones, the fill time is all ones, the class is 4 (Invalid) and the tag is 0.
- R2: The status bit positions are valid=bit0, writable=bit1, readable=bit2, dirty=bit3, secure=bit4 and prefetched=bit5. A masked update writes status to (status & ~mask) | (value & mask).
- R3: The writable query is writable AND valid, and the readable query is readable AND valid. The dirty, secure and prefetched queries show their bits directly.
- R4: A fill sets the use count to 1, stores the current time input as the fill time, and loads tag, owner, task, secure and prefetched from the fill inputs. Valid, writable, readable and dirty keep their values.
- R5: Invalidate clears all status bits and the use count. It sets owner and task to all ones and the fill time to all ones. The tag keeps its value.
- R6: The class is formed from {writable query, dirty, valid}. The codes are 111 gives 0 (Modified), 011 gives 1 (Owned), 101 gives 2 (Exclusive), 001 gives 3 (Shared) and 000 gives 4 (Invalid). Every other pattern gives 5 (Transient).
- R7: A touch with no fill and no invalidate in the same cycle adds 1 to the use count.
- R8: The use count holds at 2^REF_W-1 when it is touched again. It does not wrap.
- R9: A touch clears the prefetched bit. This clear wins over a masked update that tries to set that bit in the same cycle.
- R10: Invalidate wins over fill, and fill wins over touch and update. In a fill cycle, touch and update have no effect on any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inval_i | input | 1 | Invalidate command |
| insert_i | input | 1 | Fill command |
| touch_i | input | 1 | Demand access command |
| upd_en_i | input | 1 | Masked status update command |
| upd_mask_i | input | 6 | Bits of status to overwrite |
| upd_val_i | input | 6 | New values for masked bits |
| ins_tag_i | input | TAG_W | Tag loaded on fill |
| ins_secure_i | input | 1 | Secure flag loaded on fill |
| ins_prefetch_i | input | 1 | Prefetched flag loaded on fill |
| ins_owner_i | input | OWNER_W | Requester identifier loaded on fill |
| ins_task_i | input | TASK_W | Task identifier loaded on fill |
| now_time_i | input | TIME_W | Current time, stored on fill |
| status_o | output | 6 | Stored status vector |
| tag_o | output | TAG_W | Stored tag |
| ref_count_o | output | REF_W | Use count |
| owner_o | output | OWNER_W | Stored requester identifier |
| task_o | output | TASK_W | Stored task identifier |
| ins_time_o | output | TIME_W | Stored fill time |
| valid_o | output | 1 | Valid query |
| readable_o | output | 1 | Readable query |
| writable_o | output | 1 | Writable query |
| dirty_o | output | 1 | Dirty query |
| prefetched_o | output | 1 | Prefetched query |
| secure_o | output | 1 | Secure query |
| class_o | output | 3 | Coherence class code |

## Verification
The status vector is walked through every class pattern with masked updates, including the patterns with valid clear and writable or dirty set. These show whether the writable query, rather than the raw writable bit, feeds the class code. Long runs of touches drive the use count into saturation. Commands are then issued together in each priority combination: fill with touch and update, invalidate with fill, and touch with an update that sets prefetched. These cases separate an ordering fault from a plain update fault. A cycle-level reference model checks every output field on every clock, so an error that shows only in one field or only after several commands is still caught.

// File: rtl/line_meta_pkg.sv
package line_meta_pkg;

    localparam int ST_W = 6;

    typedef struct packed {
        logic prefetched;  // bit 5
        logic secure;      // bit 4
        logic dirty;       // bit 3
        logic readable;    // bit 2
        logic writable;    // bit 1
        logic valid;       // bit 0
    } status_t;

    typedef enum logic [2:0] {
        CLS_MOD   = 3'd0,
        CLS_OWN   = 3'd1,
        CLS_EXCL  = 3'd2,
        CLS_SHR   = 3'd3,
        CLS_INV   = 3'd4,
        CLS_TRANS = 3'd5
    } line_class_e;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_INVAL  = 2'd1,
        OP_FILL   = 2'd2,
        OP_MODIFY = 2'd3
    } line_op_e;

    // Command ordering: invalidate, then fill, then touch/update together.
    function automatic line_op_e pick_op(input logic inval, input logic fill,
                                         input logic touch, input logic upd);
        if (inval)             return OP_INVAL;
        else if (fill)         return OP_FILL;
        else if (touch || upd) return OP_MODIFY;
        else                   return OP_HOLD;
    endfunction

    function automatic line_class_e classify(input status_t s);
        logic wq;
        wq = s.writable & s.valid;
        case ({wq, s.dirty, s.valid})
            3'b111:  return CLS_MOD;
            3'b011:  return CLS_OWN;
            3'b101:  return CLS_EXCL;
            3'b001:  return CLS_SHR;
            3'b000:  return CLS_INV;
            default: return CLS_TRANS;
        endcase
    endfunction

endpackage

// File: rtl/lmr_status_reg.sv
module lmr_status_reg
    import line_meta_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  line_op_e           op,
    input  logic               touch,
    input  logic               upd_en,
    input  logic [ST_W-1:0]    upd_mask,
    input  logic [ST_W-1:0]    upd_val,
    input  logic               fill_secure,
    input  logic               fill_prefetch,
    output status_t            status
);

    status_t nxt;
    logic [ST_W-1:0] merged;

    always_comb begin
        merged = (status & ~upd_mask) | (upd_val & upd_mask);
        nxt    = status;
        case (op)
            OP_INVAL: nxt = '0;
            OP_FILL: begin
                nxt.secure     = fill_secure;
                nxt.prefetched = fill_prefetch;
            end
            OP_MODIFY: begin
                if (upd_en) nxt = status_t'(merged);
                if (touch)  nxt.prefetched = 1'b0;
            end
            default: nxt = status;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= nxt;
    end

endmodule

// File: rtl/lmr_ref_ctr.sv
module lmr_ref_ctr
    import line_meta_pkg::*;
#(
    parameter int REF_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  line_op_e          op,
    input  logic              touch,
    output logic [REF_W-1:0]  count
);

    localparam logic [REF_W-1:0] CNT_MAX = '1;
    localparam logic [REF_W-1:0] CNT_ONE = REF_W'(1);

    logic at_max;
    assign at_max = (count == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case (op)
                OP_INVAL:  count <= '0;
                OP_FILL:   count <= CNT_ONE;
                OP_MODIFY: if (touch && !at_max) count <= count + CNT_ONE;
                default:   count <= count;
            endcase
        end
    end

endmodule

// File: rtl/lmr_field.sv
module lmr_field
    import line_meta_pkg::*;
#(
    parameter int             W          = 8,
    parameter logic [W-1:0]   RST_VAL    = '1,
    parameter bit             INV_CLEARS = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  line_op_e      op,
    input  logic [W-1:0]  load_val,
    output logic [W-1:0]  q
);

    logic inv_hit;

    generate
        if (INV_CLEARS) begin : g_inv_clear
            assign inv_hit = (op == OP_INVAL);
        end else begin : g_inv_keep
            assign inv_hit = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || inv_hit)     q <= RST_VAL;
        else if (op == OP_FILL) q <= load_val;
    end

endmodule

// File: rtl/lmr_query.sv
module lmr_query
    import line_meta_pkg::*;
(
    input  status_t      status,
    output logic         valid_q,
    output logic         readable_q,
    output logic         writable_q,
    output logic         dirty_q,
    output logic         prefetched_q,
    output logic         secure_q,
    output line_class_e  cls
);

    assign valid_q      = status.valid;
    assign readable_q   = status.readable & status.valid;
    assign writable_q   = status.writable & status.valid;
    assign dirty_q      = status.dirty;
    assign prefetched_q = status.prefetched;
    assign secure_q     = status.secure;
    assign cls          = classify(status);

endmodule

// File: rtl/line_meta_reg.sv
module line_meta_reg
    import line_meta_pkg::*;
#(
    parameter int TAG_W   = 20,
    parameter int REF_W   = 4,
    parameter int OWNER_W = 8,
    parameter int TASK_W  = 16,
    parameter int TIME_W  = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                inval_i,
    input  logic                insert_i,
    input  logic                touch_i,
    input  logic                upd_en_i,
    input  logic [5:0]          upd_mask_i,
    input  logic [5:0]          upd_val_i,
    input  logic [TAG_W-1:0]    ins_tag_i,
    input  logic                ins_secure_i,
    input  logic                ins_prefetch_i,
    input  logic [OWNER_W-1:0]  ins_owner_i,
    input  logic [TASK_W-1:0]   ins_task_i,
    input  logic [TIME_W-1:0]   now_time_i,
    output logic [5:0]          status_o,
    output logic [TAG_W-1:0]    tag_o,
    output logic [REF_W-1:0]    ref_count_o,
    output logic [OWNER_W-1:0]  owner_o,
    output logic [TASK_W-1:0]   task_o,
    output logic [TIME_W-1:0]   ins_time_o,
    output logic                valid_o,
    output logic                readable_o,
    output logic                writable_o,
    output logic                dirty_o,
    output logic                prefetched_o,
    output logic                secure_o,
    output logic [2:0]          class_o
);

    line_op_e    op;
    status_t     st;
    line_class_e cls;

    assign op = pick_op(inval_i, insert_i, touch_i, upd_en_i);

    lmr_status_reg u_status (
        .clk           (clk),
        .rst           (rst),
        .op            (op),
        .touch         (touch_i),
        .upd_en        (upd_en_i),
        .upd_mask      (upd_mask_i),
        .upd_val       (upd_val_i),
        .fill_secure   (ins_secure_i),
        .fill_prefetch (ins_prefetch_i),
        .status        (st)
    );

    lmr_ref_ctr #(.REF_W(REF_W)) u_ref (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .touch (touch_i),
        .count (ref_count_o)
    );

    lmr_field #(.W(TAG_W), .RST_VAL('0), .INV_CLEARS(1'b0)) u_tag (
        .clk (clk), .rst (rst), .op (op), .load_val (ins_tag_i), .q (tag_o)
    );

    lmr_field #(.W(OWNER_W), .RST_VAL('1), .INV_CLEARS(1'b1)) u_owner (
        .clk (clk), .rst (rst), .op (op), .load_val (ins_owner_i), .q (owner_o)
    );

    lmr_field #(.W(TASK_W), .RST_VAL('1), .INV_CLEARS(1'b1)) u_task (
        .clk (clk), .rst (rst), .op (op), .load_val (ins_task_i), .q (task_o)
    );

    lmr_field #(.W(TIME_W), .RST_VAL('1), .INV_CLEARS(1'b1)) u_time (
        .clk (clk), .rst (rst), .op (op), .load_val (now_time_i), .q (ins_time_o)
    );

    lmr_query u_query (
        .status       (st),
        .valid_q      (valid_o),
        .readable_q   (readable_o),
        .writable_q   (writable_o),
        .dirty_q      (dirty_o),
        .prefetched_q (prefetched_o),
        .secure_q     (secure_o),
        .cls          (cls)
    );

    assign status_o = st;
    assign class_o  = cls;

endmodule

// File: rtl/line_meta_chk.sv
module line_meta_chk #(
    parameter int REF_W   = 4,
    parameter int OWNER_W = 8,
    parameter int TASK_W  = 16,
    parameter int TIME_W  = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                inval_i,
    input logic                insert_i,
    input logic                touch_i,
    input logic [TIME_W-1:0]   now_time_i,
    input logic [5:0]          status_o,
    input logic [REF_W-1:0]    ref_count_o,
    input logic [OWNER_W-1:0]  owner_o,
    input logic [TASK_W-1:0]   task_o,
    input logic [TIME_W-1:0]   ins_time_o,
    input logic                valid_o,
    input logic                readable_o,
    input logic                writable_o,
    input logic                dirty_o,
    input logic                prefetched_o,
    input logic [2:0]          class_o
);

    localparam logic [REF_W-1:0]   RMAX  = '1;
    localparam logic [OWNER_W-1:0] OWN1  = '1;
    localparam logic [TASK_W-1:0]  TASK1 = '1;
    localparam logic [TIME_W-1:0]  TIME1 = '1;

    AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        inval_i |=> (status_o == 6'd0) && (ref_count_o == '0) && (owner_o == OWN1)
                    && (task_o == TASK1) && (ins_time_o == TIME1)); // R5

    AST_FILL_LOADS: assert property (@(posedge clk) disable iff (rst)
        (insert_i && !inval_i) |=> (ref_count_o == REF_W'(1))
                    && (ins_time_o == $past(now_time_i))
                    && (status_o[0] == $past(status_o[0]))); // R4

    AST_FILL_BLOCKS_UPD: assert property (@(posedge clk) disable iff (rst)
        (insert_i && !inval_i) |=> (status_o[3:0] == $past(status_o[3:0]))); // R10

    AST_REF_STEP: assert property (@(posedge clk) disable iff (rst)
        (touch_i && !inval_i && !insert_i && ref_count_o != RMAX)
            |=> (ref_count_o == $past(ref_count_o) + REF_W'(1))); // R7

    AST_REF_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (touch_i && !inval_i && !insert_i && ref_count_o == RMAX)
            |=> (ref_count_o == RMAX)); // R8

    AST_TOUCH_CLEARS_PF: assert property (@(posedge clk) disable iff (rst)
        (touch_i && !inval_i && !insert_i) |=> !prefetched_o); // R9

    AST_MOD_CLASS: assert property (@(posedge clk) disable iff (rst)
        (class_o == 3'd0) |-> (writable_o && dirty_o && valid_o)); // R6

    AST_READ_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        readable_o |-> valid_o); // R3

endmodule

bind line_meta_reg line_meta_chk #(
    .REF_W(REF_W), .OWNER_W(OWNER_W), .TASK_W(TASK_W), .TIME_W(TIME_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .inval_i      (inval_i),
    .insert_i     (insert_i),
    .touch_i      (touch_i),
    .now_time_i   (now_time_i),
    .status_o     (status_o),
    .ref_count_o  (ref_count_o),
    .owner_o      (owner_o),
    .task_o       (task_o),
    .ins_time_o   (ins_time_o),
    .valid_o      (valid_o),
    .readable_o   (readable_o),
    .writable_o   (writable_o),
    .dirty_o      (dirty_o),
    .prefetched_o (prefetched_o),
    .class_o      (class_o)
);

// File: tb/sim_line_meta_reg.sv
`timescale 1ns/1ps
module sim_line_meta_reg;

    localparam int TAG_W = 20, REF_W = 4, OWNER_W = 8, TASK_W = 16, TIME_W = 32;
    localparam int REF_MAX = (1 << REF_W) - 1;

    logic clk = 1'b0;
    logic rst;
    logic inval_i, insert_i, touch_i, upd_en_i;
    logic [5:0] upd_mask_i, upd_val_i;
    logic [TAG_W-1:0] ins_tag_i;
    logic ins_secure_i, ins_prefetch_i;
    logic [OWNER_W-1:0] ins_owner_i;
    logic [TASK_W-1:0] ins_task_i;
    logic [TIME_W-1:0] now_time_i;
    logic [5:0] status_o;
    logic [TAG_W-1:0] tag_o;
    logic [REF_W-1:0] ref_count_o;
    logic [OWNER_W-1:0] owner_o;
    logic [TASK_W-1:0] task_o;
    logic [TIME_W-1:0] ins_time_o;
    logic valid_o, readable_o, writable_o, dirty_o, prefetched_o, secure_o;
    logic [2:0] class_o;

    always #10 clk = ~clk;

    line_meta_reg u0 (.*);

    int n_checks = 0;
    int n_fail = 0;

    // reference model state
    logic [5:0] m_st;
    int         m_ref;
    logic [TAG_W-1:0] m_tag;
    logic [OWNER_W-1:0] m_own;
    logic [TASK_W-1:0] m_task;
    logic [TIME_W-1:0] m_time;

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_class(input logic [5:0] s);
        logic w;
        w = s[1] & s[0];
        case ({w, s[3], s[0]})
            3'b111: return 0;
            3'b011: return 1;
            3'b101: return 2;
            3'b001: return 3;
            3'b000: return 4;
            default: return 5;
        endcase
    endfunction

    task automatic model_invalid();
        m_st = 6'd0; m_ref = 0;
        m_own = '1; m_task = '1; m_time = '1;
    endtask

    task automatic model_clock();
        if (rst) begin
            model_invalid();
            m_tag = '0;
        end else if (inval_i) begin
            model_invalid();
        end else if (insert_i) begin
            m_ref = 1; m_time = now_time_i; m_tag = ins_tag_i;
            m_own = ins_owner_i; m_task = ins_task_i;
            m_st[4] = ins_secure_i; m_st[5] = ins_prefetch_i;
        end else begin
            if (upd_en_i) m_st = (m_st & ~upd_mask_i) | (upd_val_i & upd_mask_i);
            if (touch_i) begin
                if (m_ref < REF_MAX) m_ref++;
                m_st[5] = 1'b0;
            end
        end
    endtask

    task automatic compare_all();
        chk("R2 status", status_o, m_st);
        chk("R7 refcount", ref_count_o, m_ref);
        chk("R4 tag", tag_o, m_tag);
        chk("R4 owner", owner_o, m_own);
        chk("R4 task", task_o, m_task);
        chk("R4 fill time", ins_time_o, m_time);
        chk("R3 readable", readable_o, m_st[2] & m_st[0]);
        chk("R3 writable", writable_o, m_st[1] & m_st[0]);
        chk("R3 flags", {valid_o, dirty_o, prefetched_o, secure_o},
            {m_st[0], m_st[3], m_st[5], m_st[4]});
        chk("R6 class", class_o, exp_class(m_st));
    endtask

    task automatic idle_inputs();
        inval_i = 0; insert_i = 0; touch_i = 0; upd_en_i = 0;
        upd_mask_i = '0; upd_val_i = '0;
    endtask

    task automatic step();
        @(posedge clk);
        model_clock();
        @(negedge clk);
        now_time_i = now_time_i + 1;
        compare_all();
        idle_inputs();
    endtask

    task automatic do_upd(input logic [5:0] mask, input logic [5:0] val);
        upd_en_i = 1; upd_mask_i = mask; upd_val_i = val;
        step();
    endtask

    task automatic do_fill(input logic [TAG_W-1:0] t, input logic sec, input logic pf);
        insert_i = 1; ins_tag_i = t; ins_secure_i = sec; ins_prefetch_i = pf;
        ins_owner_i = t[7:0] ^ 8'h5A; ins_task_i = t[15:0] + 16'h11;
        step();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle_inputs();
        ins_tag_i = '0; ins_secure_i = 0; ins_prefetch_i = 0;
        ins_owner_i = '0; ins_task_i = '0; now_time_i = 32'd1000;
        m_st = '0; m_ref = 0; m_tag = '0; m_own = '1; m_task = '1; m_time = '1;
        rst = 1;
        @(negedge clk);
        step(); step();
        // R1: reset state
        chk("R1 reset status", status_o, 0);
        chk("R1 reset class", class_o, 4);
        chk("R1 reset time", ins_time_o, 64'hFFFF_FFFF);
        rst = 0;
        step();

        // R2: set valid + readable -> shared
        do_upd(6'h05, 6'h05);
        chk("R6 shared", class_o, 3);
        // R4: fill keeps valid/readable, loads identity
        do_fill(20'hABCDE, 1'b1, 1'b1);
        chk("R4 fill ref one", ref_count_o, 1);
        chk("R4 fill keeps valid", valid_o, 1);
        chk("R4 fill prefetched", prefetched_o, 1);
        // R9: touch clears prefetched; R7 increment
        touch_i = 1; step();
        chk("R9 touch clears prefetched", prefetched_o, 0);
        chk("R7 touch increments", ref_count_o, 2);
        // walk class patterns
        do_upd(6'h02, 6'h02); chk("R6 exclusive", class_o, 2);
        do_upd(6'h08, 6'h08); chk("R6 modified", class_o, 0);
        do_upd(6'h02, 6'h00); chk("R6 owned", class_o, 1);
        do_upd(6'h01, 6'h00); chk("R6 dirty invalid transient", class_o, 5);
        do_upd(6'h0A, 6'h02); chk("R3 writable needs valid", writable_o, 0);
        chk("R3 readable needs valid", readable_o, 0);
        chk("R6 writable bit alone is invalid", class_o, 4);
        do_upd(6'h3F, 6'h00);
        // R8: saturate
        for (int i = 0; i < 20; i++) begin
            touch_i = 1; step();
        end
        chk("R8 saturated count", ref_count_o, REF_MAX);
        // R9: touch beats update setting prefetched
        touch_i = 1; do_upd(6'h20, 6'h20);
        chk("R9 touch wins over set", prefetched_o, 0);
        // R10: fill with touch and update in same cycle
        touch_i = 1; upd_en_i = 1; upd_mask_i = 6'h0F; upd_val_i = 6'h0F;
        do_fill(20'h12345, 1'b0, 1'b1);
        chk("R10 fill ignores touch", ref_count_o, 1);
        chk("R10 fill ignores update", status_o[3:0], 0);
        chk("R10 fill ignores touch clear", prefetched_o, 1);
        // R10/R5: invalidate beats fill
        do_upd(6'h0F, 6'h0F);
        inval_i = 1; do_fill(20'h77777, 1'b1, 1'b1);
        chk("R5 invalidate clears status", status_o, 0);
        chk("R5 invalidate keeps tag", tag_o, 20'h12345);
        chk("R5 owner invalid code", owner_o, 8'hFF);
        chk("R10 invalidate beats fill ref", ref_count_o, 0);
        // refill and check time capture
        do_fill(20'h00042, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            touch_i = 1; step();
        end
        chk("R7 count after three touches", ref_count_o, 4);
        step(); step();
        summary();
    end

endmodule